// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block works out the following program counter for a 32-bit RISC core whose instructions are one word long and word aligned. Each cycle it receives the current PC, the instruction word at that PC, and the values of the two source registers named by the instruction. It then chooses between straight-line flow, a conditional branch on equality or inequality, a region-relative jump, a jump that also saves a return address, and a jump through a register.

All candidate targets are computed in parallel and one of them is chosen by the decoded instruction kind. The result is registered, so the outputs describe the instruction that was presented one clock earlier. For the linking jump the block also raises a write request for register 31, with the address of the following instruction as the value to store. A jump through a register whose value is not word aligned raises a flag. The PC is still loaded, with its two low bits cleared.

Top module: `npc_unit`

## Requirements
- R1: For any instruction other than a taken branch or a jump, the next PC is PC+4, wrapping modulo 2^32, and redirect_o stays low.
- R2: Opcode 4 (instruction bits 31:26) is taken when rs_val_i equals rt_val_i. When taken, the next PC is PC+4 plus the sign-extended 16-bit field (bits 15:0) multiplied by 4. When not taken, the next PC is PC+4.
- R3: Opcode 5 uses the same target arithmetic as R2 but is taken when rs_val_i differs from rt_val_i.
- R4: Opcode 2 jumps to bits 31:28 of the current PC followed by the 26-bit field (bits 25:0) shifted left by 2, and sets redirect_o.
- R5: Opcode 3 jumps like R4. It also asserts link_we_o with link_addr_o = 31 and link_val_o = PC+4.
- R6: Opcode 0 with function field (bits 5:0) equal to 8 jumps to rs_val_i with its two low bits cleared. misalign_o is high exactly when those two low bits were nonzero.
- R7: Outputs are registered one clock after the inputs are sampled. While rst_ni is low, next_pc_o equals RESET_PC (default 0) and link_we_o, link_addr_o, misalign_o and redirect_o are 0.
- R8: The two low bits of next_pc_o are always zero.
- R9: link_we_o is asserted only for opcode 3, and link_addr_o is 0 whenever link_we_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Registered next program counter |
| link_val_o | output | 32 | Return address (PC+4) of the registered instruction |
| link_we_o | output | 1 | Write request for the return-address register |
| link_addr_o | output | 5 | Destination register of the link write |
| misalign_o | output | 1 | Register jump target had nonzero low bits |
| redirect_o | output | 1 | Control flow left the sequential path |

## Verification
Several properties are checked on every cycle against the inputs of the previous cycle: word alignment of the next PC, the return address and destination of every link write, the restriction of link writes to the linking jump, the register-jump target together with its misalignment flag, sequential flow whenever no redirect is reported, preservation of the top PC bits on region jumps, and a not-taken equality branch when the operands differ. The exact branch target arithmetic can only be shown by the bench's scenarios. These cover the largest forward and backward offsets, a branch back onto itself, jumps at the edges of a 256 MB region, and PC wrap-around at the top of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned FN_W   = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned IDX_W  = 26;
  localparam int unsigned REG_W  = 5;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP   = 6'd2;
  localparam logic [OP_W-1:0] OP_JLNK  = 6'd3;
  localparam logic [OP_W-1:0] OP_BREQ  = 6'd4;
  localparam logic [OP_W-1:0] OP_BRNE  = 6'd5;
  localparam logic [FN_W-1:0] FN_JREG  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JMP,
    FLOW_JLNK,
    FLOW_JREG
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] funct_i,
  output flow_e           kind_o
);
  always_comb begin
    unique case (op_i)
      OP_BREQ:  kind_o = FLOW_BREQ;
      OP_BRNE:  kind_o = FLOW_BRNE;
      OP_JMP:   kind_o = FLOW_JMP;
      OP_JLNK:  kind_o = FLOW_JLNK;
      OP_RTYPE: kind_o = (funct_i == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
      default:  kind_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]    pc_i,
  input  logic [IDX_W-1:0] field_i,
  input  logic [AW-1:0]    rs_val_i,
  input  logic [AW-1:0]    rt_val_i,
  output logic [AW-1:0]    pc4_o,
  output logic [AW-1:0]    br_tgt_o,
  output logic [AW-1:0]    jmp_tgt_o,
  output logic [AW-1:0]    reg_tgt_o,
  output logic             eq_o,
  output logic             reg_mis_o
);
  localparam int unsigned SEXT_W = AW - IMM_W - 2;
  localparam int unsigned HI_W   = AW - IDX_W - 2;

  logic [IMM_W-1:0] imm;
  logic [AW-1:0]    br_off;

  assign imm    = field_i[IMM_W-1:0];
  assign br_off = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};

  assign pc4_o     = pc_i + AW'(4);
  // relative to the following instruction
  assign br_tgt_o  = pc4_o + br_off;
  // region bits come from the current PC
  assign jmp_tgt_o = {pc_i[AW-1 -: HI_W], field_i, 2'b00};
  assign reg_tgt_o = {rs_val_i[AW-1:2], 2'b00};
  assign reg_mis_o = |rs_val_i[1:0];
  assign eq_o      = ~|(rs_val_i ^ rt_val_i);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned    AW       = 32,
  parameter int unsigned    RA_IDX   = 31,
  parameter logic [AW-1:0]  RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     pc_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [AW-1:0]     rs_val_i,
  input  logic [AW-1:0]     rt_val_i,
  output logic [AW-1:0]     next_pc_o,
  output logic [AW-1:0]     link_val_o,
  output logic              link_we_o,
  output logic [REG_W-1:0]  link_addr_o,
  output logic              misalign_o,
  output logic              redirect_o
);
  localparam logic [REG_W-1:0] RA_ADDR = REG_W'(RA_IDX);

  flow_e       kind;
  logic [AW-1:0] pc4, br_tgt, jmp_tgt, reg_tgt;
  logic        eq, reg_mis;

  logic [AW-1:0] nxt_d;
  logic        red_d, lwe_d, mis_d;

  npc_decode i_dec (
    .op_i    (instr_i[ILEN-1 -: OP_W]),
    .funct_i (instr_i[FN_W-1:0]),
    .kind_o  (kind)
  );

  npc_targets #(.AW(AW)) i_tgt (
    .pc_i      (pc_i),
    .field_i   (instr_i[IDX_W-1:0]),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .pc4_o     (pc4),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt),
    .reg_tgt_o (reg_tgt),
    .eq_o      (eq),
    .reg_mis_o (reg_mis)
  );

  always_comb begin
    nxt_d = pc4;
    red_d = 1'b0;
    lwe_d = 1'b0;
    mis_d = 1'b0;
    unique case (kind)
      FLOW_BREQ: if (eq)  begin nxt_d = br_tgt; red_d = 1'b1; end
      FLOW_BRNE: if (!eq) begin nxt_d = br_tgt; red_d = 1'b1; end
      FLOW_JMP:  begin nxt_d = jmp_tgt; red_d = 1'b1; end
      FLOW_JLNK: begin nxt_d = jmp_tgt; red_d = 1'b1; lwe_d = 1'b1; end
      FLOW_JREG: begin nxt_d = reg_tgt; red_d = 1'b1; mis_d = reg_mis; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o   <= RESET_PC;
      link_val_o  <= '0;
      link_we_o   <= 1'b0;
      link_addr_o <= '0;
      misalign_o  <= 1'b0;
      redirect_o  <= 1'b0;
    end else begin
      next_pc_o   <= nxt_d;
      link_val_o  <= pc4;
      link_we_o   <= lwe_d;
      link_addr_o <= lwe_d ? RA_ADDR : '0;
      misalign_o  <= mis_d;
      redirect_o  <= red_d;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned RA_IDX = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    pc_i,
  input logic [OP_W-1:0]  op_i,
  input logic [FN_W-1:0]  funct_i,
  input logic [AW-1:0]    rs_val_i,
  input logic [AW-1:0]    rt_val_i,
  input logic [AW-1:0]    next_pc_o,
  input logic [AW-1:0]    link_val_o,
  input logic             link_we_o,
  input logic [REG_W-1:0] link_addr_o,
  input logic             misalign_o,
  input logic             redirect_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R8
  aligned_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_pc_o[1:0] == 2'b00);

  // R5
  link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && link_we_o |-> link_val_o == $past(pc_i) + AW'(4)
                           && link_addr_o == REG_W'(RA_IDX) && redirect_o);

  // R9
  link_only_jal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && link_we_o |-> $past(op_i) == OP_JLNK);

  // R9
  link_addr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_we_o |-> link_addr_o == '0);

  // R6
  jreg_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_RTYPE && $past(funct_i) == FN_JREG
      |-> next_pc_o == {$past(rs_val_i[AW-1:2]), 2'b00}
          && misalign_o == ($past(rs_val_i[1:0]) != 2'b00));

  // R1
  seq_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !redirect_o |-> next_pc_o == $past(pc_i) + AW'(4) && !misalign_o);

  // R4
  region_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_JMP |-> redirect_o
      && next_pc_o[AW-1:28] == $past(pc_i[AW-1:28]));

  // R2
  beq_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_BREQ && $past(rs_val_i) != $past(rt_val_i)
      |-> !redirect_o);
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .RA_IDX(RA_IDX)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .op_i        (instr_i[31:26]),
  .funct_i     (instr_i[5:0]),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .next_pc_o   (next_pc_o),
  .link_val_o  (link_val_o),
  .link_we_o   (link_we_o),
  .link_addr_o (link_addr_o),
  .misalign_o  (misalign_o),
  .redirect_o  (redirect_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic [31:0] next_pc_o, link_val_o;
  logic        link_we_o, misalign_o, redirect_o;
  logic [4:0]  link_addr_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  npc_unit i_npc_unit (
    .clk_i, .rst_ni, .pc_i, .instr_i, .rs_val_i, .rt_val_i,
    .next_pc_o, .link_val_o, .link_we_o, .link_addr_o, .misalign_o, .redirect_o
  );

  // reference outputs
  logic [31:0] e_pc, e_lv;
  logic        e_we, e_mis, e_red;
  logic [4:0]  e_la;

  task automatic model(input logic [31:0] pc, ins, rs, rt);
    int op, fn;
    longint off;
    op = int'(ins[31:26]);
    fn = int'(ins[5:0]);
    e_lv = pc + 32'd4;
    e_pc = e_lv; e_we = 0; e_mis = 0; e_red = 0; e_la = 0;
    if ((op == 4 && rs == rt) || (op == 5 && rs != rt)) begin
      off = longint'($signed(ins[15:0])) * 4;
      e_pc = 32'(longint'(pc) + 4 + off);
      e_red = 1;
    end else if (op == 2 || op == 3) begin
      e_pc = (pc & 32'hF000_0000) | (32'(ins[25:0]) * 32'd4);
      e_red = 1;
      if (op == 3) begin e_we = 1; e_la = 5'd31; end
    end else if (op == 0 && fn == 8) begin
      e_pc = rs - (rs % 4);
      e_mis = (rs % 4) != 0;
      e_red = 1;
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (next_pc_o !== e_pc || link_we_o !== e_we || link_addr_o !== e_la ||
        misalign_o !== e_mis || redirect_o !== e_red ||
        (e_we && link_val_o !== e_lv)) begin
      n_bad++;
      $display("FAIL %s: got pc=%h we=%b la=%0d lv=%h mis=%b red=%b exp pc=%h we=%b la=%0d lv=%h mis=%b red=%b",
               tag, next_pc_o, link_we_o, link_addr_o, link_val_o, misalign_o, redirect_o,
               e_pc, e_we, e_la, e_lv, e_mis, e_red);
    end
  endtask

  task automatic step(input logic [31:0] pc, ins, rs, rt, input string tag);
    @(negedge clk_i);
    pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
    model(pc, ins, rs, rt);
    @(posedge clk_i);
    #5;
    compare(tag);
  endtask

  function automatic logic [31:0] br(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction
  function automatic logic [31:0] jp(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  localparam logic [31:0] JREG = {6'd0, 5'd9, 15'd0, 6'd8};
  localparam logic [31:0] ADDI = {6'd8, 5'd1, 5'd2, 16'h0008};
  localparam logic [31:0] ADDR = {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd32};

  initial begin
    #15;
    // R7 reset values while held in reset
    e_pc = 0; e_lv = 0; e_we = 0; e_mis = 0; e_red = 0; e_la = 0;
    compare("R7 reset");
    @(negedge clk_i); rst_ni = 1'b1;

    step(32'h0040_0000, ADDR, 1, 1, "R1 r-type add");
    step(32'h0040_0004, ADDI, 0, 0, "R1 op8 with funct 8");
    step(32'hFFFF_FFFC, ADDR, 0, 0, "R1 wrap");
    step(32'h0040_0010, {6'd0, 20'd0, 6'd9}, 32'h100, 0, "R1 funct9 sequential");
    step(32'h0040_1000, br(6'd4, 16'h0010), 7, 7, "R2 beq fwd taken");
    step(32'h0040_1000, br(6'd4, 16'h0010), 7, 8, "R2 beq not taken");
    step(32'h0040_1000, br(6'd4, 16'hFFFF), 3, 3, "R2 beq self loop");
    step(32'h0040_1000, br(6'd4, 16'h7FFF), 0, 0, "R2 beq max fwd");
    step(32'h0040_1000, br(6'd4, 16'h8000), 0, 0, "R2 beq max back");
    step(32'h0000_0000, br(6'd4, 16'hFFFE), 5, 5, "R2 beq below zero wrap");
    step(32'h1000_0000, br(6'd5, 16'hFFF0), 1, 2, "R3 bne back taken");
    step(32'h1000_0000, br(6'd5, 16'hFFF0), 9, 9, "R3 bne not taken");
    step(32'h1000_0000, br(6'd5, 16'h0001), 32'h8000_0000, 0, "R3 bne fwd msb diff");
    step(32'h0FFF_FFFC, jp(6'd2, 26'h3FF_FFFF), 0, 0, "R4 j region top");
    step(32'hF000_0000, jp(6'd2, 26'h000_0000), 0, 0, "R4 j region base");
    step(32'h5123_4560, jp(6'd2, 26'h012_3456), 0, 0, "R4 j mid");
    step(32'h0040_0020, jp(6'd3, 26'h010_0040), 0, 0, "R5 jal");
    step(32'hAFFF_FFFC, jp(6'd3, 26'h000_0001), 0, 0, "R5 jal region edge");
    step(32'h0040_0030, JREG, 32'h0040_0024, 0, "R6 jr aligned");
    step(32'h0040_0030, JREG, 32'h1234_5677, 0, "R6 jr misaligned");
    step(32'h0040_0030, JREG, 32'hFFFF_FFFE, 0, "R6 jr misaligned top");
    step(32'h0040_0034, ADDR, 0, 0, "R9 no link after jr");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins, a, b, pc;
      int sel;
      sel = $urandom_range(0, 6);
      pc  = {$urandom} & 32'hFFFF_FFFC;
      a   = $urandom;
      b   = ($urandom_range(0, 1) == 1) ? a : $urandom;
      case (sel)
        0: ins = br(6'd4, 16'($urandom));
        1: ins = br(6'd5, 16'($urandom));
        2: ins = jp(6'd2, 26'($urandom));
        3: ins = jp(6'd3, 26'($urandom));
        4: ins = JREG;
        5: ins = {6'd0, 20'($urandom), 6'($urandom)};
        default: ins = $urandom;
      endcase
      step(pc, ins, a, b, "R8 mixed");
    end

    @(negedge clk_i); rst_ni = 1'b0;
    #5;
    e_pc = 0; e_lv = 0; e_we = 0; e_mis = 0; e_red = 0; e_la = 0;
    compare("R7 reset mid-run");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule